// File: doc/BRIEF.md
# Tone Pair Steering and Receive Latch

This block replaces the resistor-capacitor timing network that sits behind a dual-tone detector. The detector supplies a raw presence signal and a 4-bit code naming the detected tone pair. The block counts clock cycles to confirm that presence holds long enough to count as a character. It then captures the code and raises a guard output. After a short settling interval it publishes the code on its receive data output and sets a delayed steering flag. The same counter then confirms that absence holds long enough to count as a real interdigit pause before the flag drops. Brief gaps in presence do not end a character, and brief bursts of presence never start one.

The flag doubles as a status bit. A pending interrupt is raised when the flag rises and is shown on an active-low output while interrupt mode is enabled. A one-cycle read strobe on the receive data register clears that pending interrupt but leaves the flag alone. The presence time, pause time and settle delay are parameters counted in clock cycles.

Top module: `tone_steer`

## Requirements
- R1: When `early_i` has been high for `PRESENT_CYC` consecutive rising clock edges, the value of `code_i` at the last of those edges is captured and `guard_o` is high from that edge on.
- R2: A presence burst of fewer than `PRESENT_CYC` consecutive high edges captures nothing: `guard_o` stays low and `dv_flag_o` does not rise.
- R3: After capture, `guard_o` stays high while `early_i` stays high and is low from the first edge at which `early_i` is sampled low.
- R4: `dv_flag_o` rises exactly `SETTLE_CYC` edges after the capture edge, and at that edge `rx_data_o` takes the captured code.
- R5: `rx_data_o` changes only at the edge where `dv_flag_o` rises; changes of `code_i` after capture have no effect on it.
- R6: Once `dv_flag_o` is high, it clears at the `PAUSE_CYC`-th consecutive edge with `early_i` low; a low gap shorter than that leaves it high.
- R7: While `dv_flag_o` is high (or settling), a new presence burst of any length captures nothing and does not raise `guard_o`; a new pair is accepted only after the flag has cleared through a valid pause.
- R8: A pending interrupt is set at the edge where `dv_flag_o` rises; `irq_n_o` is low exactly when a pending interrupt exists and `irq_en_i` is high.
- R9: A high `rd_data_i` at an edge clears the pending interrupt without changing `dv_flag_o`.
- R10: The pending interrupt is also cleared at the edge where `dv_flag_o` clears.
- R11: After reset, `guard_o` and `dv_flag_o` are low, `rx_data_o` is 0 and `irq_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| early_i | input | 1 | Raw tone-pair presence from the detector |
| code_i | input | 4 | Code of the detected tone pair |
| irq_en_i | input | 1 | Interrupt mode enable |
| rd_data_i | input | 1 | One-cycle strobe marking a read of the receive data register |
| guard_o | output | 1 | Guard output, high from capture while presence lasts |
| rx_data_o | output | 4 | Receive data register |
| dv_flag_o | output | 1 | Delayed steering flag, also the status bit |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The main function is driven with presence bursts one edge short of the validation time, exactly at it, and well beyond it, which separates an off-by-one in the presence count from a correct capture. A burst whose code changes after capture shows that the published data comes from the capture edge and not from a later sample. A short dropout followed by a second burst tells a pause counter that restarts on presence apart from one that keeps accumulating, and shows that no second pair slips in before a real pause. Runs with interrupt mode on and off, with and without a read strobe, separate the read-clear and flag-clear paths of the interrupt.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOLD   = 2'd2
    } steer_st_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/tsp_run_cnt.sv
module tsp_run_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] last_i,
    output logic         hit_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign hit_o = inc_i && (cnt_q.cnt == last_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (inc_i) begin
            if (hit_o) cnt_d.cnt = '0;
            else       cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tsp_irq.sv
module tsp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic drop_i,
    input  logic en_i,
    output logic irq_n_o
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set_i)              irq_d.pend = 1'b1;
        else if (rd_i || drop_i) irq_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_n_o = ~(en_i & irq_q.pend);

endmodule

// File: rtl/tsp_steer.sv
module tsp_steer
    import tone_steer_pkg::*;
#(
    parameter int unsigned PRESENT_CYC = 16,
    parameter int unsigned PAUSE_CYC   = 16,
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              guard_o,
    output logic              flag_o,
    output logic [CODE_W-1:0] data_o,
    output logic              rise_o,
    output logic              fall_o
);

    localparam int unsigned MAXC = max3(PRESENT_CYC, PAUSE_CYC, SETTLE_CYC);
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] PRESENT_LAST = CW'(PRESENT_CYC - 1);
    localparam logic [CW-1:0] PAUSE_LAST   = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST  = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        steer_st_e         st;
        logic              guard;
        logic              flag;
        logic [CODE_W-1:0] cap;
        logic [CODE_W-1:0] data;
    } steer_t;

    steer_t s_d, s_q;

    logic          run_clr;
    logic          run_inc;
    logic [CW-1:0] run_last;
    logic          run_hit;

    tsp_run_cnt #(.W(CW)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (run_clr),
        .inc_i  (run_inc),
        .last_i (run_last),
        .hit_o  (run_hit)
    );

    always_comb begin
        s_d      = s_q;
        run_clr  = 1'b0;
        run_inc  = 1'b0;
        run_last = PRESENT_LAST;
        rise_o   = 1'b0;
        fall_o   = 1'b0;
        // guard follows presence once set, never re-arms by itself
        s_d.guard = s_q.guard & early_i;
        unique case (s_q.st)
            ST_IDLE: begin
                run_inc  = early_i;
                run_clr  = ~early_i;
                run_last = PRESENT_LAST;
                if (run_hit) begin
                    s_d.st    = ST_SETTLE;
                    s_d.guard = 1'b1;
                    s_d.cap   = code_i;
                end
            end
            ST_SETTLE: begin
                run_inc  = 1'b1;
                run_last = SETTLE_LAST;
                if (run_hit) begin
                    s_d.st   = ST_HOLD;
                    s_d.flag = 1'b1;
                    s_d.data = s_q.cap;
                    rise_o   = 1'b1;
                end
            end
            ST_HOLD: begin
                run_inc  = ~early_i;
                run_clr  = early_i;
                run_last = PAUSE_LAST;
                if (run_hit) begin
                    s_d.st   = ST_IDLE;
                    s_d.flag = 1'b0;
                    fall_o   = 1'b1;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.guard <= 1'b0;
            s_q.flag  <= 1'b0;
            s_q.cap   <= '0;
            s_q.data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign guard_o = s_q.guard;
    assign flag_o  = s_q.flag;
    assign data_o  = s_q.data;

endmodule

// File: rtl/tone_steer.sv
module tone_steer #(
    parameter int unsigned PRESENT_CYC = 16,
    parameter int unsigned PAUSE_CYC   = 16,
    parameter int unsigned SETTLE_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       early_i,
    input  logic [3:0] code_i,
    input  logic       irq_en_i,
    input  logic       rd_data_i,
    output logic       guard_o,
    output logic [3:0] rx_data_o,
    output logic       dv_flag_o,
    output logic       irq_n_o
);

    logic flag_rise;
    logic flag_fall;

    tsp_steer #(
        .PRESENT_CYC (PRESENT_CYC),
        .PAUSE_CYC   (PAUSE_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .CODE_W      (4)
    ) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .early_i (early_i),
        .code_i  (code_i),
        .guard_o (guard_o),
        .flag_o  (dv_flag_o),
        .data_o  (rx_data_o),
        .rise_o  (flag_rise),
        .fall_o  (flag_fall)
    );

    tsp_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_rise),
        .rd_i    (rd_data_i),
        .drop_i  (flag_fall),
        .en_i    (irq_en_i),
        .irq_n_o (irq_n_o)
    );

endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
    parameter int unsigned PRESENT_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       early_i,
    input logic       irq_en_i,
    input logic       rd_data_i,
    input logic       guard_o,
    input logic [3:0] rx_data_o,
    input logic       dv_flag_o,
    input logic       irq_n_o
);

    localparam int unsigned RW = $clog2(PRESENT_CYC + 1);

    // consecutive presence edges, saturating at the validation length
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_q <= '0;
        else if (!early_i)              run_q <= '0;
        else if (run_q != RW'(PRESENT_CYC)) run_q <= run_q + 1'b1;
    end

    // R1 and R2: capture only after a full presence run
    assert_full_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard_o) |-> (run_q == RW'(PRESENT_CYC)));

    assert_guard_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guard_o) |-> !$past(early_i));

    assert_data_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> $rose(dv_flag_o));

    assert_pause_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_flag_o) |-> !$past(early_i));

    assert_one_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard_o) |-> !dv_flag_o);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (dv_flag_o && irq_en_i));

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_i |=> (irq_n_o || $rose(dv_flag_o)));

endmodule

bind tone_steer tone_steer_chk #(.PRESENT_CYC(PRESENT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .early_i   (early_i),
    .irq_en_i  (irq_en_i),
    .rd_data_i (rd_data_i),
    .guard_o   (guard_o),
    .rx_data_o (rx_data_o),
    .dv_flag_o (dv_flag_o),
    .irq_n_o   (irq_n_o)
);

// File: tb/tone_steer_tb.sv
module tone_steer_tb;

    localparam int PRESENT = 8;
    localparam int PAUSE   = 6;
    localparam int SETTLE  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       early = 1'b0;
    logic [3:0] code = 4'h0;
    logic       irq_en = 1'b0;
    logic       rd = 1'b0;
    logic       guard;
    logic [3:0] rx;
    logic       flag;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    int pops   = 0;
    bit armed  = 1'b1;
    bit done   = 1'b0;
    logic [3:0] exp_q[$];

    always #10 clk = ~clk;

    tone_steer #(
        .PRESENT_CYC (PRESENT),
        .PAUSE_CYC   (PAUSE),
        .SETTLE_CYC  (SETTLE)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_i   (early),
        .code_i    (code),
        .irq_en_i  (irq_en),
        .rd_data_i (rd),
        .guard_o   (guard),
        .rx_data_o (rx),
        .dv_flag_o (flag),
        .irq_n_o   (irq_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expected codes as the flag rises
    int  cyc = 0;
    int  grd_cyc = 0;
    logic prev_flag = 1'b0;
    logic prev_guard = 1'b0;
    logic [3:0] prev_rx = 4'h0;
    int  stray = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (guard && !prev_guard) grd_cyc = cyc;
            if (flag && !prev_flag) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected capture", int'(rx), -1);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    pops++;
                    chk(rx == e, "R4 data", int'(rx), int'(e));
                    chk(cyc - grd_cyc == SETTLE, "R4 settle", cyc - grd_cyc, SETTLE);
                    chk(irq_n == !irq_en, "R8 irq", int'(irq_n), int'(!irq_en));
                end
            end else if (rx != prev_rx) begin
                stray++;
            end
        end
        prev_flag  = flag;
        prev_guard = guard;
        prev_rx    = rx;
    end

    // driver: one presence burst followed by an absence gap
    task automatic pair(input logic [3:0] c, input int on, input int off,
                        input bit glitch, input bit do_read);
        bit reg_now;
        bit flag_start;
        int need;
        reg_now = armed && (on >= PRESENT);
        if (reg_now) begin
            exp_q.push_back(c);
            armed = 1'b0;
        end
        early = 1'b1;
        code  = c;
        for (int i = 1; i <= on; i++) begin
            @(negedge clk);
            if (glitch && i == PRESENT + 1) code = ~c;
            if (do_read && i == PRESENT + SETTLE + 1) rd = 1'b1;
            if (do_read && i == PRESENT + SETTLE + 2) begin
                rd = 1'b0;
                chk(irq_n == 1'b1, "R9 irq cleared", int'(irq_n), 1);
                chk(flag == 1'b1, "R9 flag kept", int'(flag), 1);
            end
        end
        if (on < PRESENT)
            chk(guard == 1'b0, "R2 short burst", int'(guard), 0);
        else if (!reg_now)
            chk(guard == 1'b0, "R7 no second pair", int'(guard), 0);
        else
            chk(guard == 1'b1, "R1 guard", int'(guard), 1);
        flag_start = flag;
        early = 1'b0;
        for (int k = 1; k <= off; k++) begin
            @(negedge clk);
            if (k == 1) chk(guard == 1'b0, "R3 guard drop", int'(guard), 0);
            if (flag_start && k == PAUSE - 1)
                chk(flag == 1'b1, "R6 before pause", int'(flag), 1);
            if (flag_start && k == PAUSE) begin
                chk(flag == 1'b0, "R6 pause end", int'(flag), 0);
                chk(irq_n == 1'b1, "R10 irq on clear", int'(irq_n), 1);
            end
        end
        if (flag_start && off < PAUSE)
            chk(flag == 1'b1, "R6 dropout ignored", int'(flag), 1);
        if (reg_now) begin
            need = PAUSE + ((PRESENT + SETTLE > on) ? (PRESENT + SETTLE - on) : 0);
            armed = (off >= need);
        end else if (flag_start) begin
            armed = (off >= PAUSE);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(guard == 1'b0, "R11 guard", int'(guard), 0);
        chk(flag == 1'b0, "R11 flag", int'(flag), 0);
        chk(rx == 4'h0, "R11 data", int'(rx), 0);
        chk(irq_n == 1'b1, "R11 irq", int'(irq_n), 1);
        rst_n = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);

        pair(4'h1, 14, 10, 1'b0, 1'b0);             // R1 R4 plain capture
        pair(4'h5, PRESENT - 1, 10, 1'b0, 1'b0);    // R2 one edge short
        pair(4'hA, 14, 10, 1'b1, 1'b0);             // R5 code changes after capture
        pair(4'h3, 16, 10, 1'b0, 1'b1);             // R9 read strobe
        pair(4'h7, 14, PAUSE - 3, 1'b0, 1'b0);      // R6 short dropout
        pair(4'hC, 14, 10, 1'b0, 1'b0);             // R7 burst during held flag
        irq_en = 1'b0;
        pair(4'h9, 14, 10, 1'b0, 1'b0);             // R8 interrupt masked
        irq_en = 1'b1;
        pair(4'h0, PRESENT, 12, 1'b0, 1'b0);        // R1 exact boundary
        pair(4'h6, 14, 10, 1'b0, 1'b0);             // R4 after boundary case

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all captured", exp_q.size(), 0);
        chk(pops == 7, "R7 capture count", pops, 7);
        chk(stray == 0, "R5 stray data change", stray, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule